// File: doc/BRIEF.md
# Lane Alignment Character Replacer

This block handles the data-phase alignment characters for one lane of a serial converter link, one octet per clock. On the transmit side it receives user octets with the frame-end and multiframe-end markers that the lane's counters produce. The last octet of a frame is swapped for a control character when the rule for the current mode says so. With scrambling off, the rule is that the octet repeats the previous frame's last octet. With scrambling on, the rule is that the octet already equals the control code for that boundary.

On the receive side the block takes decoded octets with their control flag and the local frame and multiframe markers. It puts back the original data value wherever an alignment character appears. It raises a one-cycle misalignment flag when a control character turns up somewhere the local counters say it cannot be. A link controller uses that flag to decide whether to drop back to resynchronisation.

Each direction keeps its reference octet in a small state machine with three states. REF_IDLE means the lane is outside the data phase and the reference is held at zero. REF_EMPTY means the data phase has begun but no frame has ended yet. REF_HELD means a reference octet is valid. The transitions are as follows:
- phase_enter: REF_IDLE goes to REF_EMPTY, or straight to REF_HELD if a frame ends in the same cycle.
- first_capture: REF_EMPTY goes to REF_HELD.
- phase_exit: any state goes to REF_IDLE when the data-phase input is low.

Top module: `align_char_replacer`

## Requirements
- R1: After reset, every output is 0: both valid outputs, both octet outputs, `tx_out_ctrl` and `rx_misalign`.
- R2: Each direction has exactly one cycle of latency, and each output valid is the input valid delayed by one cycle. On the transmit side, any octet that is not a frame's last octet, or that arrives while `tx_data_phase` is low, leaves unchanged with `tx_out_ctrl` = 0.
- R3: With `tx_scramble_en` = 0, a frame-end octet that equals the reference octet is replaced and sent with `tx_out_ctrl` = 1. At a multiframe end it becomes 0x7C (/A/). At any other frame end it becomes 0xFC (/F/).
- R4: The transmit reference is the original data value of the previous frame's last octet, never the control character that replaced it. It is cleared while `tx_data_phase` is low, so the first data-phase frame is never replaced in R3 mode.
- R5: With `tx_scramble_en` = 1, a multiframe-end octet of 0x7C is sent as 0x7C with control set. A non-multiframe frame-end octet of 0xFC is sent as 0xFC with control set. Every other frame-end octet, including 0xFC at a multiframe end and 0x7C at a plain frame end, passes unchanged with control clear.
- R6: With `rx_scramble_en` = 0 in the data phase, a received control 0x7C or 0xFC is restored to the receive reference. The receive reference is the restored value of the previous frame's last octet, and it reads 0 while `rx_data_phase` is low or before the first frame end.
- R7: With `rx_scramble_en` = 1 in the data phase, a received control 0xFC is restored to 0xFC and a received control 0x7C is restored to 0x7C.
- R8: In the data phase, `rx_misalign` is 1 in the output cycle of any of these octets: a control 0x7C without `rx_mf_end`, a control 0xFC without `rx_frame_end`, or a control 0xFC with `rx_mf_end`. The octet is still restored as in R6 or R7.
- R9: In the data phase, any control octet without `rx_frame_end` sets `rx_misalign`. A control octet other than 0x7C or 0xFC at a frame end passes unchanged without the flag.
- R10: While `rx_data_phase` is low, the received octet passes unchanged and `rx_misalign` stays 0 whatever `rx_ctrl` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data_phase | input | 1 | Transmit lane is in the data phase |
| tx_scramble_en | input | 1 | Transmit scrambling enabled |
| tx_valid | input | 1 | Transmit octet valid |
| tx_octet | input | 8 | Transmit user octet |
| tx_frame_end | input | 1 | Octet is the last of its frame |
| tx_mf_end | input | 1 | Octet is the last of its multiframe |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_octet | output | 8 | Transmit octet after replacement |
| tx_out_ctrl | output | 1 | Transmit octet is a control character |
| rx_data_phase | input | 1 | Receive lane is in the data phase |
| rx_scramble_en | input | 1 | Receive scrambling enabled |
| rx_valid | input | 1 | Received octet valid |
| rx_octet | input | 8 | Received decoded octet |
| rx_ctrl | input | 1 | Received octet is a control character |
| rx_frame_end | input | 1 | Local counter: last octet of a frame |
| rx_mf_end | input | 1 | Local counter: last octet of a multiframe |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_octet | output | 8 | Restored octet |
| rx_misalign | output | 1 | Alignment character out of place |

## Verification
Suppose a reference machine stayed in REF_HELD across a phase exit, or captured the replacement code instead of the data. The transmit side would then replace a first data frame, or miss a repeat. That shows up on `tx_out_ctrl` one cycle after the frame-end octet. On the receive side the same fault restores an alignment character to a stale value, visible on `rx_out_octet` in that same next cycle. A fault in the position decode shows up as a spurious or missing `rx_misalign` pulse one cycle after the offending octet. Looping transmit output back into the receive input makes any asymmetry between the two reference machines appear as a mismatch against the original data one cycle later.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int OCTET_W = 8;
    localparam logic [OCTET_W-1:0] CODE_MF_ALIGN = 8'h7C;
    localparam logic [OCTET_W-1:0] CODE_FR_ALIGN = 8'hFC;

    typedef enum logic [1:0] {
        REF_IDLE  = 2'd0,
        REF_EMPTY = 2'd1,
        REF_HELD  = 2'd2
    } ref_state_t;
endpackage

// File: rtl/acr_ref_fsm.sv
module acr_ref_fsm
    import acr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_on,
    input  logic               capture,
    input  logic [OCTET_W-1:0] cap_octet,
    output logic               ref_ok,
    output logic [OCTET_W-1:0] ref_octet
);
    ref_state_t state_q, state_d;
    logic [OCTET_W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_IDLE:  state_d = !phase_on ? REF_IDLE
                               : (capture ? REF_HELD : REF_EMPTY);
            REF_EMPTY: state_d = !phase_on ? REF_IDLE
                               : (capture ? REF_HELD : REF_EMPTY);
            REF_HELD:  state_d = !phase_on ? REF_IDLE : REF_HELD;
            default:   state_d = REF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !phase_on) begin
            ref_q <= '0;
        end else if (capture) begin
            ref_q <= cap_octet;
        end
    end

    always_comb begin
        ref_ok    = (state_q == REF_HELD);
        ref_octet = ref_q;
    end

    // R4: leaving the data phase empties the reference
    assert_ref_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_on |=> (!ref_ok && ref_octet == '0));

    // R4: a capture in the data phase makes the captured value the reference
    assert_ref_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_on && capture) |=> (ref_ok && ref_octet == $past(cap_octet)));
endmodule

// File: rtl/acr_tx_path.sv
module acr_tx_path
    import acr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_phase,
    input  logic               scramble_en,
    input  logic               in_valid,
    input  logic [OCTET_W-1:0] in_octet,
    input  logic               frame_end,
    input  logic               mf_end,
    output logic               out_valid,
    output logic [OCTET_W-1:0] out_octet,
    output logic               out_ctrl
);
    logic               ref_ok;
    logic [OCTET_W-1:0] ref_octet;
    logic               boundary;
    logic               replace;
    logic [OCTET_W-1:0] code;

    assign boundary = in_valid && data_phase && frame_end;

    acr_ref_fsm i_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_on  (data_phase),
        .capture   (boundary),
        .cap_octet (in_octet),
        .ref_ok    (ref_ok),
        .ref_octet (ref_octet)
    );

    always_comb begin
        code    = mf_end ? CODE_MF_ALIGN : CODE_FR_ALIGN;
        replace = 1'b0;
        if (boundary) begin
            if (scramble_en) begin
                replace = (in_octet == code);
            end else begin
                replace = ref_ok && (in_octet == ref_octet);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_octet <= '0;
            out_ctrl  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_octet <= replace ? code : in_octet;
            out_ctrl  <= replace;
        end
    end

    // R2: non-boundary octets pass unchanged without control
    assert_tx_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(data_phase && frame_end)) |=>
        (!out_ctrl && out_octet == $past(in_octet) && out_valid));

    // R5: scrambled multiframe end carrying the /A/ value goes out as control
    assert_tx_scr_mf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && scramble_en && mf_end && in_octet == CODE_MF_ALIGN) |=>
        (out_ctrl && out_octet == CODE_MF_ALIGN));

    // R3: a control output is always one of the two alignment codes
    assert_tx_ctrl_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctrl |-> (out_octet == CODE_MF_ALIGN || out_octet == CODE_FR_ALIGN));
endmodule

// File: rtl/acr_rx_path.sv
module acr_rx_path
    import acr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_phase,
    input  logic               scramble_en,
    input  logic               in_valid,
    input  logic [OCTET_W-1:0] in_octet,
    input  logic               in_ctrl,
    input  logic               frame_end,
    input  logic               mf_end,
    output logic               out_valid,
    output logic [OCTET_W-1:0] out_octet,
    output logic               misalign
);
    logic               ref_ok;
    logic [OCTET_W-1:0] ref_octet;
    logic               active;
    logic               is_a;
    logic               is_f;
    logic               bad_pos;
    logic [OCTET_W-1:0] restored;

    assign active = in_valid && data_phase;

    always_comb begin
        is_a     = active && in_ctrl && (in_octet == CODE_MF_ALIGN);
        is_f     = active && in_ctrl && (in_octet == CODE_FR_ALIGN);
        restored = in_octet;
        if (is_a || is_f) begin
            restored = scramble_en ? in_octet : ref_octet;
        end
        bad_pos = (is_a && !mf_end)
               || (is_f && (!frame_end || mf_end))
               || (active && in_ctrl && !frame_end);
    end

    acr_ref_fsm i_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_on  (data_phase),
        .capture   (active && frame_end),
        .cap_octet (restored),
        .ref_ok    (ref_ok),
        .ref_octet (ref_octet)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_octet <= '0;
            misalign  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_octet <= restored;
            misalign  <= bad_pos;
        end
    end

    // R10: outside the data phase nothing is flagged or changed
    assert_rx_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !data_phase) |=> (!misalign && out_octet == $past(in_octet)));

    // R9: a control octet off the frame end is always flagged
    assert_rx_ctrl_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && in_ctrl && !frame_end) |=> misalign);

    // R7: scrambled restoration keeps the alignment code value
    assert_rx_scr_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && in_ctrl && scramble_en && in_octet == CODE_FR_ALIGN) |=>
        (out_octet == CODE_FR_ALIGN));

    // R6: a restored octet while no reference is held reads zero
    assert_rx_empty_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_a && !scramble_en && !ref_ok) |=> (out_octet == '0));
endmodule

// File: rtl/align_char_replacer.sv
module align_char_replacer
    import acr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_data_phase,
    input  logic       tx_scramble_en,
    input  logic       tx_valid,
    input  logic [7:0] tx_octet,
    input  logic       tx_frame_end,
    input  logic       tx_mf_end,
    output logic       tx_out_valid,
    output logic [7:0] tx_out_octet,
    output logic       tx_out_ctrl,
    input  logic       rx_data_phase,
    input  logic       rx_scramble_en,
    input  logic       rx_valid,
    input  logic [7:0] rx_octet,
    input  logic       rx_ctrl,
    input  logic       rx_frame_end,
    input  logic       rx_mf_end,
    output logic       rx_out_valid,
    output logic [7:0] rx_out_octet,
    output logic       rx_misalign
);
    acr_tx_path i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_phase  (tx_data_phase),
        .scramble_en (tx_scramble_en),
        .in_valid    (tx_valid),
        .in_octet    (tx_octet),
        .frame_end   (tx_frame_end),
        .mf_end      (tx_mf_end),
        .out_valid   (tx_out_valid),
        .out_octet   (tx_out_octet),
        .out_ctrl    (tx_out_ctrl)
    );

    acr_rx_path i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_phase  (rx_data_phase),
        .scramble_en (rx_scramble_en),
        .in_valid    (rx_valid),
        .in_octet    (rx_octet),
        .in_ctrl     (rx_ctrl),
        .frame_end   (rx_frame_end),
        .mf_end      (rx_mf_end),
        .out_valid   (rx_out_valid),
        .out_octet   (rx_out_octet),
        .misalign    (rx_misalign)
    );

    // R1: both directions leave reset quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!tx_out_valid && !tx_out_ctrl && !rx_out_valid && !rx_misalign));
endmodule

// File: tb/test_align_char_replacer.sv
module test_align_char_replacer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       tx_dp, tx_scr, tx_v, tx_fe, tx_mf;
    logic [7:0] tx_o;
    logic       tx_ov, tx_oc;
    logic [7:0] tx_oo;
    logic       lb;
    logic       d_dp, d_scr, d_v, d_c, d_fe, d_mf;
    logic [7:0] d_o;
    logic       l_dp, l_scr, l_v, l_fe, l_mf;
    logic       rx_dp, rx_scr, rx_v, rx_c, rx_fe, rx_mf;
    logic [7:0] rx_o;
    logic       rx_ov, rx_mis;
    logic [7:0] rx_oo;
    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    assign rx_dp  = lb ? l_dp  : d_dp;
    assign rx_scr = lb ? l_scr : d_scr;
    assign rx_v   = lb ? l_v   : d_v;
    assign rx_o   = lb ? tx_oo : d_o;
    assign rx_c   = lb ? tx_oc : d_c;
    assign rx_fe  = lb ? l_fe  : d_fe;
    assign rx_mf  = lb ? l_mf  : d_mf;

    always @(posedge clk) begin
        l_dp <= tx_dp; l_scr <= tx_scr; l_v <= tx_v; l_fe <= tx_fe; l_mf <= tx_mf;
    end

    align_char_replacer i_align_char_replacer (
        .clk(clk), .rst_n(rst_n),
        .tx_data_phase(tx_dp), .tx_scramble_en(tx_scr), .tx_valid(tx_v),
        .tx_octet(tx_o), .tx_frame_end(tx_fe), .tx_mf_end(tx_mf),
        .tx_out_valid(tx_ov), .tx_out_octet(tx_oo), .tx_out_ctrl(tx_oc),
        .rx_data_phase(rx_dp), .rx_scramble_en(rx_scr), .rx_valid(rx_v),
        .rx_octet(rx_o), .rx_ctrl(rx_c), .rx_frame_end(rx_fe), .rx_mf_end(rx_mf),
        .rx_out_valid(rx_ov), .rx_out_octet(rx_oo), .rx_misalign(rx_mis)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rx_step(input logic dp, input logic scr, input logic [7:0] o,
                           input logic c, input logic fe, input logic mf);
        d_dp = dp; d_scr = scr; d_v = 1'b1; d_o = o; d_c = c; d_fe = fe; d_mf = mf;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        lb = 1'b1;
        tx_dp = 0; tx_scr = 0; tx_v = 0; tx_o = 0; tx_fe = 0; tx_mf = 0;
        d_dp = 0; d_scr = 0; d_v = 0; d_o = 0; d_c = 0; d_fe = 0; d_mf = 0;
        repeat (3) tick();
        // R1: reset state
        chk("R1 tx_out_valid", tx_ov, 0);
        chk("R1 tx_out_ctrl", tx_oc, 0);
        chk("R1 tx_out_octet", tx_oo, 0);
        chk("R1 rx_out_valid", rx_ov, 0);
        chk("R1 rx_misalign", rx_mis, 0);
        chk("R1 rx_out_octet", rx_oo, 0);
        rst_n = 1'b1;

        // Loopback sweep: frames of 2 octets, 4 frames per multiframe
        for (int scr = 0; scr < 2; scr++) begin
            for (int seed = 0; seed < 4; seed++) begin
                logic [7:0] m_ref;
                logic       m_ok;
                logic [7:0] last_fe;
                logic [7:0] prev_orig;
                logic       prev_ok;
                m_ref = 0; m_ok = 0; last_fe = 8'h11; prev_ok = 0; prev_orig = 0;
                for (int i = -4; i < 24; i++) begin
                    logic fe, mf, dp, rep;
                    logic [7:0] o, eo;
                    int fidx;
                    dp   = (i >= 0);
                    fidx = (i < 0) ? 0 : i / 2;
                    fe   = (i % 2 != 0) || (i == -3) || (i == -1);
                    mf   = fe && dp && (fidx % 4 == 3);
                    if (!dp) o = (i == -3) ? 8'h7C : 8'hFC;
                    else if (fe) begin
                        case ((fidx * 3 + seed) % 4)
                            0: o = 8'h7C;
                            1: o = 8'hFC;
                            2: o = 8'h5A + 8'(fidx);
                            default: o = last_fe;
                        endcase
                        last_fe = o;
                    end else begin
                        case ((fidx + seed) % 3)
                            0: o = 8'h7C;
                            1: o = 8'hFC;
                            default: o = 8'h20 + 8'(i);
                        endcase
                    end
                    tx_dp = dp; tx_scr = scr[0]; tx_v = 1; tx_o = o; tx_fe = fe; tx_mf = mf;
                    rep = 0;
                    if (dp && fe) begin
                        if (scr != 0) rep = mf ? (o == 8'h7C) : (o == 8'hFC);
                        else          rep = m_ok && (o == m_ref);
                        m_ref = o; m_ok = 1;
                    end else if (!dp) begin
                        m_ref = 0; m_ok = 0;
                    end
                    eo = rep ? (mf ? 8'h7C : 8'hFC) : o;
                    tick();
                    if (!dp)          chk("R2 tx idle ctrl", tx_oc, 0);
                    else if (!fe)     chk("R2 tx nonfinal ctrl", tx_oc, 0);
                    else if (scr != 0) chk("R5 tx scr ctrl", tx_oc, rep);
                    else if (fidx == 0) chk("R4 tx first frame ctrl", tx_oc, 0);
                    else              chk("R3 tx repeat ctrl", tx_oc, rep);
                    chk("R2 tx octet", tx_oo, eo);
                    chk("R2 tx valid", tx_ov, 1);
                    if (prev_ok) begin
                        chk(scr != 0 ? "R7 rx loopback octet" : "R6 rx loopback octet",
                            rx_oo, prev_orig);
                        chk("R8 rx loopback misalign", rx_mis, 0);
                    end
                    prev_orig = o; prev_ok = 1;
                end
            end
        end

        // Directed receive cases
        lb = 1'b0;
        tx_v = 0; tx_dp = 0;
        rx_step(1, 0, 8'h00, 0, 0, 0);
        rx_step(1, 0, 8'h42, 0, 1, 0);
        rx_step(1, 0, 8'h7C, 1, 1, 1);
        chk("R6 rx A restored to ref", rx_oo, 8'h42);
        chk("R6 rx A aligned no flag", rx_mis, 0);
        rx_step(1, 0, 8'hFC, 1, 1, 0);
        chk("R6 rx F restored to carried ref", rx_oo, 8'h42);
        rx_step(0, 0, 8'h7C, 1, 1, 0);
        chk("R10 rx idle passthru", rx_oo, 8'h7C);
        chk("R10 rx idle no flag", rx_mis, 0);
        rx_step(1, 0, 8'h7C, 1, 1, 1);
        chk("R6 rx cleared ref", rx_oo, 8'h00);
        rx_step(1, 1, 8'h7C, 1, 1, 0);
        chk("R8 rx A off mf end", rx_mis, 1);
        chk("R7 rx A restored", rx_oo, 8'h7C);
        rx_step(1, 1, 8'hFC, 1, 1, 1);
        chk("R8 rx F at mf end", rx_mis, 1);
        rx_step(1, 1, 8'hFC, 1, 1, 0);
        chk("R7 rx F restored", rx_oo, 8'hFC);
        chk("R7 rx F aligned no flag", rx_mis, 0);
        rx_step(1, 1, 8'hFC, 1, 0, 0);
        chk("R8 rx F off frame end", rx_mis, 1);
        rx_step(1, 1, 8'hBC, 1, 0, 0);
        chk("R9 rx ctrl nonfinal", rx_mis, 1);
        rx_step(1, 1, 8'hBC, 1, 1, 0);
        chk("R9 rx other ctrl at end", rx_mis, 0);
        chk("R9 rx other ctrl octet", rx_oo, 8'hBC);
        rx_step(1, 1, 8'h7C, 0, 0, 0);
        chk("R9 rx data 7C no flag", rx_mis, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule